// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the memory side of interrupt entry and interrupt return for a 16-bit core that uses segmented real-mode addressing. On an interrupt request carrying an 8-bit vector number, it saves the processor state on the stack. The flags word goes first, then the code segment, then the instruction pointer. It then reads the four-byte entry for that vector from the table at the bottom of memory and loads the new code segment and instruction pointer from it. On a return request it reads the three saved words back off the stack in the opposite order.

The core supplies its current stack segment, stack pointer, flags, code segment and instruction pointer. The block samples these on the cycle a sequence starts and returns the updated values when it signals completion. All memory traffic goes through one request/ready port. That port is either 8 or 16 bits wide, chosen by a parameter. On an 8-bit port each 16-bit word takes two byte accesses, low byte first. Only one sequence runs at a time. A request that arrives while the block is busy is kept and starts once the running sequence has completed.

Top module: `intseq_top`

## Requirements
- R1: A single-cycle `int_req` in idle starts entry. The block writes three words in this order: the flags to SS*16+SP-2, the code segment to SS*16+SP-4, and the instruction pointer to SS*16+SP-6. Every word is stored little-endian.
- R2: The flags word written to the stack is the value of `flags_in` at the start. After entry, `flags_out` equals that value with bit 9 (interrupt enable) and bit 8 (trap) cleared.
- R3: After the writes, the block reads the vector entry at physical address vector*4. Bytes 0 and 1 become `ip_out` (low byte first). Bytes 2 and 3 become `cs_out`.
- R4: After entry, `sp_out` equals `sp_in`-6 modulo 2^16. Each stack address is SS*16+SP computed on 20 bits, so SP wraps within the segment. While busy, SP changes by at most 2 per cycle.
- R5: A single-cycle `iret_req` in idle starts return. The block reads the instruction pointer at SS*16+SP, the code segment at +2 and the flags at +4. It loads all three, and `sp_out` equals `sp_in`+6.
- R6: `busy` is high from the cycle after the accepted request until the end of the sequence. `done` is high for exactly one cycle at the end, and `busy` is also high in that cycle.
- R7: A request that arrives while busy is kept. Its sequence starts after `done`. The vector number is taken on the cycle the request is raised.
- R8: If `int_req` and `iret_req` arrive in the same idle cycle, entry runs first and return runs after it.
- R9: While `mem_req` is high and `mem_rdy` is low, `mem_addr`, `mem_we` and `mem_wdata` stay constant. Wait states change only timing, never results.
- R10: With an 8-bit port, each word becomes two byte accesses: the low byte at the word address, then the high byte at address+1.
- R11: Reset clears `busy`, `done`, `mem_req` and the register outputs.
- R12: `mem_req` is high only while busy. The vector fetch and the whole return sequence are reads only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_req | input | 1 | Interrupt entry request, one-cycle pulse |
| int_vec | input | 8 | Vector number, taken together with `int_req` |
| iret_req | input | 1 | Interrupt return request, one-cycle pulse |
| ss_in | input | 16 | Current stack segment |
| sp_in | input | 16 | Current stack pointer |
| flags_in | input | 16 | Current flags |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 16 | Updated stack pointer |
| flags_out | output | 16 | Updated flags |
| cs_out | output | 16 | Updated code segment |
| ip_out | output | 16 | Updated instruction pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | BUS_W | Write data |
| mem_rdata | input | BUS_W | Read data, valid with `mem_rdy` |
| mem_rdy | input | 1 | Completes the current access |

## Verification
The assertions assume a memory that never drops or changes an access on its own. They also assume that `mem_rdy` only counts while `mem_req` is high, and that the request pulses last one cycle. The bench's memory model therefore counts a programmable number of wait cycles, and only while a request is pending. It answers only the address currently presented. The stimulus raises each request for exactly one cycle, driven on the falling edge, and changes the vector number only after the request has been taken.

// File: rtl/intseq_pkg.sv
package intseq_pkg;

    localparam int ADDR_W = 20;
    localparam int WORD_W = 16;
    localparam int IF_POS = 9;
    localparam int TF_POS = 8;
    localparam logic [15:0] SP_STEP = 16'd2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PUSH_F,
        S_PUSH_CS,
        S_PUSH_IP,
        S_VEC_IP,
        S_VEC_CS,
        S_POP_IP,
        S_POP_CS,
        S_POP_F,
        S_DONE
    } seq_state_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } word_op_t;

    function automatic logic [ADDR_W-1:0] seg_phys(input logic [15:0] seg,
                                                   input logic [15:0] off);
        return {seg, 4'h0} + {4'h0, off};
    endfunction

    function automatic logic [ADDR_W-1:0] vec_entry(input logic [7:0] vec,
                                                    input logic       hi);
        return {10'h000, vec, hi, 1'b0};
    endfunction

    function automatic seq_state_e step_next(input seq_state_e s);
        case (s)
            S_PUSH_F:  return S_PUSH_CS;
            S_PUSH_CS: return S_PUSH_IP;
            S_PUSH_IP: return S_VEC_IP;
            S_VEC_IP:  return S_VEC_CS;
            S_VEC_CS:  return S_DONE;
            S_POP_IP:  return S_POP_CS;
            S_POP_CS:  return S_POP_F;
            S_POP_F:   return S_DONE;
            default:   return S_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/intseq_ctrl.sv
module intseq_ctrl
    import intseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       int_req,
    input  logic [7:0] int_vec,
    input  logic       iret_req,
    input  logic       op_done,
    output seq_state_e state,
    output logic       start_int,
    output logic       start_iret,
    output logic [7:0] vec_q,
    output logic       busy,
    output logic       done
);

    logic       pend_int;
    logic       pend_iret;
    logic [7:0] pend_vec;
    logic       want_int;
    logic       want_iret;
    logic [7:0] start_vec;

    always_comb begin
        want_int   = int_req | pend_int;
        want_iret  = iret_req | pend_iret;
        start_int  = (state == S_IDLE) && want_int;
        start_iret = (state == S_IDLE) && !want_int && want_iret;
        start_vec  = pend_int ? pend_vec : int_vec;
        busy       = (state != S_IDLE);
        done       = (state == S_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_int <= 1'b0;
            pend_vec <= '0;
        end else if (int_req && !(start_int && !pend_int)) begin
            pend_int <= 1'b1;
            pend_vec <= int_vec;
        end else if (start_int) begin
            pend_int <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_iret <= 1'b0;
        end else if (iret_req && !(start_iret && !pend_iret)) begin
            pend_iret <= 1'b1;
        end else if (start_iret) begin
            pend_iret <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
        end else if (start_int) begin
            vec_q <= start_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start_int)       state <= S_PUSH_F;
                    else if (start_iret) state <= S_POP_IP;
                end
                S_DONE:  state <= S_IDLE;
                default: if (op_done) state <= step_next(state);
            endcase
        end
    end

endmodule

// File: rtl/intseq_regs.sv
module intseq_regs
    import intseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  seq_state_e  state,
    input  logic        start_int,
    input  logic        start_iret,
    input  logic [7:0]  vec_q,
    input  logic        op_done,
    input  logic [15:0] rdata,
    input  logic [15:0] ss_in,
    input  logic [15:0] sp_in,
    input  logic [15:0] flags_in,
    input  logic [15:0] cs_in,
    input  logic [15:0] ip_in,
    output logic [15:0] sp_q,
    output logic [15:0] flags_q,
    output logic [15:0] cs_q,
    output logic [15:0] ip_q,
    output word_op_t    op
);

    logic [15:0] ss_q;
    logic [15:0] push_sp;

    always_ff @(posedge clk) begin
        if (rst) begin
            ss_q    <= '0;
            sp_q    <= '0;
            flags_q <= '0;
            cs_q    <= '0;
            ip_q    <= '0;
        end else if (start_int || start_iret) begin
            ss_q    <= ss_in;
            sp_q    <= sp_in;
            flags_q <= flags_in;
            cs_q    <= cs_in;
            ip_q    <= ip_in;
        end else if (op_done) begin
            case (state)
                S_PUSH_F: begin
                    sp_q            <= sp_q - SP_STEP;
                    flags_q[IF_POS] <= 1'b0;
                    flags_q[TF_POS] <= 1'b0;
                end
                S_PUSH_CS, S_PUSH_IP: sp_q <= sp_q - SP_STEP;
                S_VEC_IP: ip_q <= rdata;
                S_VEC_CS: cs_q <= rdata;
                S_POP_IP: begin
                    ip_q <= rdata;
                    sp_q <= sp_q + SP_STEP;
                end
                S_POP_CS: begin
                    cs_q <= rdata;
                    sp_q <= sp_q + SP_STEP;
                end
                S_POP_F: begin
                    flags_q <= rdata;
                    sp_q    <= sp_q + SP_STEP;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        push_sp  = sp_q - SP_STEP;
        op       = '0;
        case (state)
            S_PUSH_F, S_PUSH_CS, S_PUSH_IP: begin
                op.valid = 1'b1;
                op.write = 1'b1;
                op.addr  = seg_phys(ss_q, push_sp);
                op.wdata = (state == S_PUSH_F)  ? flags_q :
                           (state == S_PUSH_CS) ? cs_q : ip_q;
            end
            S_VEC_IP, S_VEC_CS: begin
                op.valid = 1'b1;
                op.addr  = vec_entry(vec_q, state == S_VEC_CS);
            end
            S_POP_IP, S_POP_CS, S_POP_F: begin
                op.valid = 1'b1;
                op.addr  = seg_phys(ss_q, sp_q);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/intseq_port.sv
module intseq_port
    import intseq_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  word_op_t          op,
    output logic              op_done,
    output logic [15:0]       rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BUS_W-1:0]  mem_wdata,
    input  logic [BUS_W-1:0]  mem_rdata,
    input  logic              mem_rdy
);

    assign mem_req = op.valid;
    assign mem_we  = op.write;

    if (BUS_W == 8) begin : g_byte
        logic       beat;
        logic [7:0] lo_q;
        logic       accept;

        assign accept    = op.valid && mem_rdy;
        assign op_done   = accept && beat;
        assign mem_addr  = op.addr + {{(ADDR_W-1){1'b0}}, beat};
        assign mem_wdata = beat ? op.wdata[15:8] : op.wdata[7:0];
        assign rdata     = {mem_rdata, lo_q};

        always_ff @(posedge clk) begin
            if (rst) begin
                beat <= 1'b0;
                lo_q <= '0;
            end else if (accept) begin
                beat <= ~beat;
                if (!beat) lo_q <= mem_rdata;
            end
        end
    end else begin : g_word
        assign op_done   = op.valid && mem_rdy;
        assign mem_addr  = op.addr;
        assign mem_wdata = op.wdata;
        assign rdata     = mem_rdata;
    end

endmodule

// File: rtl/intseq_top.sv
module intseq_top
    import intseq_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             int_req,
    input  logic [7:0]       int_vec,
    input  logic             iret_req,
    input  logic [15:0]      ss_in,
    input  logic [15:0]      sp_in,
    input  logic [15:0]      flags_in,
    input  logic [15:0]      cs_in,
    input  logic [15:0]      ip_in,
    output logic             busy,
    output logic             done,
    output logic [15:0]      sp_out,
    output logic [15:0]      flags_out,
    output logic [15:0]      cs_out,
    output logic [15:0]      ip_out,
    output logic             mem_req,
    output logic             mem_we,
    output logic [19:0]      mem_addr,
    output logic [BUS_W-1:0] mem_wdata,
    input  logic [BUS_W-1:0] mem_rdata,
    input  logic             mem_rdy
);

    seq_state_e  state;
    logic        start_int;
    logic        start_iret;
    logic [7:0]  vec_q;
    logic        op_done;
    logic [15:0] rdata;
    word_op_t    op;

    intseq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .int_req    (int_req),
        .int_vec    (int_vec),
        .iret_req   (iret_req),
        .op_done    (op_done),
        .state      (state),
        .start_int  (start_int),
        .start_iret (start_iret),
        .vec_q      (vec_q),
        .busy       (busy),
        .done       (done)
    );

    intseq_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .state      (state),
        .start_int  (start_int),
        .start_iret (start_iret),
        .vec_q      (vec_q),
        .op_done    (op_done),
        .rdata      (rdata),
        .ss_in      (ss_in),
        .sp_in      (sp_in),
        .flags_in   (flags_in),
        .cs_in      (cs_in),
        .ip_in      (ip_in),
        .sp_q       (sp_out),
        .flags_q    (flags_out),
        .cs_q       (cs_out),
        .ip_q       (ip_out),
        .op         (op)
    );

    intseq_port #(.BUS_W(BUS_W)) u_port (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .op_done   (op_done),
        .rdata     (rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rdy   (mem_rdy)
    );

endmodule

// File: rtl/intseq_chk.sv
module intseq_chk #(
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_rdy,
    input logic [19:0]      mem_addr,
    input logic [BUS_W-1:0] mem_wdata,
    input logic [15:0]      sp_out
);

    // R9: a stalled access keeps its address, direction and data
    p_hold_stalled_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R6: completion lasts one cycle
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: completion only inside a running sequence
    p_done_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R12: no memory traffic while idle
    p_req_busy_r12: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R4: stack pointer moves by at most one word per cycle while busy
    p_sp_step_r4: assert property (@(posedge clk) disable iff (rst)
        busy |=> (sp_out == $past(sp_out)) ||
                 (sp_out == $past(sp_out) - 16'd2) ||
                 (sp_out == $past(sp_out) + 16'd2));

    // R11: reset leaves the block idle and quiet
    p_reset_idle_r11: assert property (@(posedge clk)
        rst |=> (!busy && !done && !mem_req));

endmodule

bind intseq_top intseq_chk #(.BUS_W(BUS_W)) u_intseq_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_rdy   (mem_rdy),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sp_out    (sp_out)
);

// File: tb/intseq_top_bench.sv
module intseq_top_bench;

    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          int_req = 1'b0;
    logic [7:0]    int_vec = '0;
    logic          iret_req = 1'b0;
    logic [15:0]   ss_in = '0, sp_in = '0, flags_in = '0, cs_in = '0, ip_in = '0;
    logic          busy, done, mem_req, mem_we, mem_rdy;
    logic [15:0]   sp_out, flags_out, cs_out, ip_out;
    logic [19:0]   mem_addr;
    logic [BW-1:0] mem_wdata;
    logic [BW-1:0] mem_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0]  mem [0:4095];
    logic [19:0] wr_addr [0:63];
    logic [19:0] rd_addr [0:63];
    int wr_n = 0;
    int rd_n = 0;
    int wcnt = 0;
    int wait_cfg = 0;

    always #4 clk = ~clk;

    intseq_top #(.BUS_W(BW)) u_intseq_top (
        .clk(clk), .rst(rst), .int_req(int_req), .int_vec(int_vec),
        .iret_req(iret_req), .ss_in(ss_in), .sp_in(sp_in), .flags_in(flags_in),
        .cs_in(cs_in), .ip_in(ip_in), .busy(busy), .done(done),
        .sp_out(sp_out), .flags_out(flags_out), .cs_out(cs_out), .ip_out(ip_out),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
    );

    // memory model with programmable wait states
    assign mem_rdy = mem_req && (wcnt == wait_cfg);

    always_comb begin
        for (int i = 0; i < BW/8; i++)
            mem_rdata[i*8 +: 8] = mem[mem_addr[11:0] + 12'(i)];
    end

    always @(posedge clk) begin
        if (rst) begin
            wcnt <= 0;
        end else if (mem_req) begin
            if (mem_rdy) begin
                wcnt <= 0;
                if (mem_we) begin
                    for (int i = 0; i < BW/8; i++)
                        mem[mem_addr[11:0] + 12'(i)] <= mem_wdata[i*8 +: 8];
                    wr_addr[wr_n[5:0]] <= mem_addr;
                    wr_n <= wr_n + 1;
                end else begin
                    rd_addr[rd_n[5:0]] <= mem_addr;
                    rd_n <= rd_n + 1;
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_ctx(input logic [15:0] ss, sp, fl, cs, ip);
        ss_in = ss; sp_in = sp; flags_in = fl; cs_in = cs; ip_in = ip;
    endtask

    task automatic put16(input int a, input logic [15:0] v);
        mem[a] = v[7:0];
        mem[a+1] = v[15:8];
    endtask

    function automatic logic [15:0] get16(input int a);
        return {mem[a+1], mem[a]};
    endfunction

    task automatic pulse(input bit do_int, input bit do_iret, input logic [7:0] v);
        int_vec  = v;
        int_req  = do_int;
        iret_req = do_iret;
        @(negedge clk);
        int_req  = 1'b0;
        iret_req = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (done !== 1'b1 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " done seen"}, {31'd0, done}, 32'd1);
    endtask

    task automatic t_reset;
        chk("R11 busy", {31'd0, busy}, 32'd0);
        chk("R11 done", {31'd0, done}, 32'd0);
        chk("R11 mem_req", {31'd0, mem_req}, 32'd0);
        chk("R11 sp_out", {16'd0, sp_out}, 32'd0);
        chk("R11 ip_out", {16'd0, ip_out}, 32'd0);
    endtask

    task automatic t_entry_basic;
        int bw = wr_n;
        int br = rd_n;
        wait_cfg = 0;
        put16(32'h84, 16'hABCD);
        put16(32'h86, 16'hEF01);
        set_ctx(16'h0080, 16'h0100, 16'h0302, 16'h1234, 16'h5678);
        pulse(1, 0, 8'h21);
        chk("R6 busy after request", {31'd0, busy}, 32'd1);
        wait_done("R6");
        @(negedge clk);
        chk("R6 done one cycle", {31'd0, done}, 32'd0);
        chk("R1 write count", wr_n - bw, 6);
        chk("R1 R10 flags lo addr", {12'd0, wr_addr[bw]}, 32'h008FE);
        chk("R10 flags hi addr", {12'd0, wr_addr[bw+1]}, 32'h008FF);
        chk("R1 cs addr", {12'd0, wr_addr[bw+2]}, 32'h008FC);
        chk("R1 ip addr", {12'd0, wr_addr[bw+4]}, 32'h008FA);
        chk("R2 pushed flags", {16'd0, get16(32'h8FE)}, 32'h0302);
        chk("R1 pushed cs", {16'd0, get16(32'h8FC)}, 32'h1234);
        chk("R1 pushed ip", {16'd0, get16(32'h8FA)}, 32'h5678);
        chk("R3 vector read addr", {12'd0, rd_addr[br]}, 32'h00084);
        chk("R3 cs byte read addr", {12'd0, rd_addr[br+3]}, 32'h00087);
        chk("R3 ip_out", {16'd0, ip_out}, 32'hABCD);
        chk("R3 cs_out", {16'd0, cs_out}, 32'hEF01);
        chk("R2 flags_out", {16'd0, flags_out}, 32'h0002);
        chk("R4 sp_out", {16'd0, sp_out}, 32'h00FA);
    endtask

    task automatic t_return;
        int bw = wr_n;
        int br = rd_n;
        set_ctx(16'h0080, 16'h00FA, 16'h0000, 16'h0000, 16'h0000);
        pulse(0, 1, 8'h00);
        wait_done("R5");
        chk("R5 ip_out", {16'd0, ip_out}, 32'h5678);
        chk("R5 cs_out", {16'd0, cs_out}, 32'h1234);
        chk("R5 flags_out", {16'd0, flags_out}, 32'h0302);
        chk("R5 sp_out", {16'd0, sp_out}, 32'h0100);
        chk("R5 first pop addr", {12'd0, rd_addr[br]}, 32'h008FA);
        chk("R5 flags pop addr", {12'd0, rd_addr[br+4]}, 32'h008FE);
        chk("R12 no writes in return", wr_n - bw, 0);
    endtask

    task automatic t_wait_states;
        int bw = wr_n;
        wait_cfg = 2;
        put16(32'h14, 16'h2211);
        put16(32'h16, 16'h4433);
        set_ctx(16'h0080, 16'h0200, 16'hFFFF, 16'h0BAD, 16'h0F00);
        pulse(1, 0, 8'h05);
        wait_done("R9");
        chk("R9 ip_out with waits", {16'd0, ip_out}, 32'h2211);
        chk("R9 cs_out with waits", {16'd0, cs_out}, 32'h4433);
        chk("R9 R2 flags_out", {16'd0, flags_out}, 32'hFCFF);
        chk("R9 sp_out", {16'd0, sp_out}, 32'h01FA);
        chk("R9 writes", wr_n - bw, 6);
        chk("R9 pushed flags", {16'd0, get16(32'h9FE)}, 32'hFFFF);
        chk("R9 pushed ip", {16'd0, get16(32'h9FA)}, 32'h0F00);
        wait_cfg = 0;
    endtask

    task automatic t_wrap;
        int bw = wr_n;
        set_ctx(16'h0080, 16'h0002, 16'h0000, 16'h00C5, 16'h00A7);
        pulse(1, 0, 8'h21);
        wait_done("R4");
        chk("R4 flags addr at SP 0", {12'd0, wr_addr[bw]}, 32'h00800);
        chk("R4 cs addr wrapped", {12'd0, wr_addr[bw+2]}, 32'h107FE);
        chk("R4 ip addr wrapped", {12'd0, wr_addr[bw+4]}, 32'h107FC);
        chk("R4 sp_out wrapped", {16'd0, sp_out}, 32'hFFFC);
    endtask

    task automatic t_pending;
        int br;
        wait_cfg = 1;
        put16(32'h88, 16'h789A);
        put16(32'h8A, 16'h3456);
        set_ctx(16'h0080, 16'h0100, 16'h0302, 16'h1234, 16'h5678);
        pulse(1, 0, 8'h21);
        @(negedge clk);
        @(negedge clk);
        pulse(1, 0, 8'h22);
        int_vec = 8'h00;
        wait_done("R7 first");
        chk("R7 first ip_out", {16'd0, ip_out}, 32'hABCD);
        br = rd_n;
        @(negedge clk);
        wait_done("R7 second");
        chk("R7 held request ran", {16'd0, ip_out}, 32'h789A);
        chk("R7 held vector cs", {16'd0, cs_out}, 32'h3456);
        chk("R7 held vector addr", {12'd0, rd_addr[br]}, 32'h00088);
        wait_cfg = 0;
    endtask

    task automatic t_both;
        put16(32'h900, 16'h1111);
        put16(32'h902, 16'h2222);
        put16(32'h904, 16'h0200);
        set_ctx(16'h0080, 16'h0100, 16'h0302, 16'h1234, 16'h5678);
        pulse(1, 1, 8'h21);
        wait_done("R8 first");
        chk("R8 entry first sp", {16'd0, sp_out}, 32'h00FA);
        chk("R8 entry first flags", {16'd0, flags_out}, 32'h0002);
        @(negedge clk);
        wait_done("R8 second");
        chk("R8 return second sp", {16'd0, sp_out}, 32'h0106);
        chk("R8 return ip", {16'd0, ip_out}, 32'h1111);
        chk("R8 return cs", {16'd0, cs_out}, 32'h2222);
        chk("R8 return flags", {16'd0, flags_out}, 32'h0200);
        @(negedge clk);
        chk("R6 idle after both", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_entry_basic();
        t_return();
        t_wait_states();
        t_wrap();
        t_pending();
        t_both();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule